// File: doc/BRIEF.md
# Iterative Signed/Unsigned Integer Divider

This block computes the quotient or the remainder of a 32-bit integer division, signed or unsigned, for the four integer divide operations of a RISC-V core. It uses one restoring shift-and-subtract loop with its own subtractor. It does not share an adder with any other unit, and it does not multiply.

A single-cycle `start` pulse loads the dividend, the divisor and the operation select. The block then runs a fixed schedule:

- the zero test on the divisor;
- one cycle that makes the dividend non-negative;
- one cycle that makes the divisor non-negative;
- one cycle that clears the partial remainder;
- 32 shift-and-subtract steps;
- one cycle that corrects the sign and registers the result.

A zero divisor leaves the schedule after the dividend step.

The answer appears on `result` together with a one-cycle `valid` pulse. `result` holds that value until the next operation completes. The unsigned operations pass through the same cycles as the signed ones, with the absolute-value steps leaving the operands unchanged, so the latency depends only on whether the divisor is zero.

Top module: `iterDivider`

## Requirements
- R1: While reset is held and after it is released with no operation started, `valid` is 0 and `result` is 0.
- R2: The operation select is decoded as 2'b00 signed quotient, 2'b01 unsigned quotient, 2'b10 signed remainder and 2'b11 unsigned remainder. For the unsigned codes, `result` is the truncated unsigned quotient or the unsigned remainder of the two 32-bit operands.
- R3: For code 2'b00 with a nonzero divisor, `result` is the two's-complement quotient rounded toward zero. Its magnitude is negated exactly when the two operands have opposite signs.
- R4: For code 2'b10 with a nonzero divisor, `result` is the remainder that satisfies dividend = quotient*divisor + remainder. Its sign follows the dividend.
- R5: With a nonzero divisor, `valid` rises on the 37th rising clock edge, counting the edge that samples `start` as the first. This holds for all four codes.
- R6: With a zero divisor, `valid` rises on the 2nd rising edge counting the same way. `result` is all ones for the quotient codes and equals the dividend for the remainder codes, for signed and unsigned codes alike.
- R7: Signed division of 32'h80000000 by 32'hFFFFFFFF gives a quotient of 32'h80000000 and a remainder of 0.
- R8: `valid` is high for exactly one cycle per operation, and `result` changes only in the cycle in which `valid` rises.
- R9: A `start` pulse that arrives while an operation is in progress is ignored. Changes on the operand and select inputs at that time are ignored as well, and the running operation's result and latency are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; sampled only when idle |
| opSel | input | 2 | Operation code (see R2) |
| dividend | input | 32 | Dividend, sampled with `start` |
| divisor | input | 32 | Divisor, sampled with `start` |
| result | output | 32 | Quotient or remainder, held between completions |
| valid | output | 1 | One-cycle completion pulse |

## Verification
The embedded assertions watch the control schedule on every cycle:

- the step counter advances through the loop and leaves it after the last step;
- a zero divisor returns the machine to idle straight after the dividend cycle;
- `valid` never lasts two cycles;
- `result` and the captured operation code hold still outside completion and load.

Only the bench's scenarios can show that the arithmetic is right. These cover the signed rounding and remainder sign, the overflow case, the zero-divisor answers, and the exact edge counts from `start` to `valid`, all compared against reference functions over random and corner-case operands.

// File: rtl/divPkg.sv
package divPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ABS_DIVIDEND,
    ST_ABS_DIVISOR,
    ST_PREP,
    ST_ITER,
    ST_FIX
  } divState_t;

  typedef struct packed {
    logic loadOps;
    logic absDividend;
    logic absDivisor;
    logic prep;
    logic step;
    logic finish;
    logic zeroExit;
  } divStrobes_t;

  localparam logic OP_BIT_UNSIGNED = 1'b1;

  function automatic logic opIsUnsigned(input logic [1:0] op);
    return op[0] == OP_BIT_UNSIGNED;
  endfunction

  function automatic logic opIsRem(input logic [1:0] op);
    return op[1];
  endfunction

endpackage

// File: rtl/divControl.sv
module divControl
  import divPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        divZero,
  output divStrobes_t strobes
);

  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

  divState_t stateQ, stateD;
  logic [CW-1:0] stepCntQ;

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobes.loadOps = 1'b1;
          stateD = ST_ABS_DIVIDEND;
        end
      end
      ST_ABS_DIVIDEND: begin
        if (divZero) begin
          strobes.zeroExit = 1'b1;
          stateD = ST_IDLE;
        end else begin
          strobes.absDividend = 1'b1;
          stateD = ST_ABS_DIVISOR;
        end
      end
      ST_ABS_DIVISOR: begin
        strobes.absDivisor = 1'b1;
        stateD = ST_PREP;
      end
      ST_PREP: begin
        strobes.prep = 1'b1;
        stateD = ST_ITER;
      end
      ST_ITER: begin
        strobes.step = 1'b1;
        if (stepCntQ == LAST_STEP) stateD = ST_FIX;
      end
      ST_FIX: begin
        strobes.finish = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      stepCntQ <= '0;
    end else begin
      stateQ <= stateD;
      if (strobes.prep)      stepCntQ <= '0;
      else if (strobes.step) stepCntQ <= stepCntQ + 1'b1;
    end
  end

  AST_ITER_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ITER && stepCntQ != LAST_STEP) |=> (stateQ == ST_ITER && stepCntQ == $past(stepCntQ) + 1'b1)); // R5
  AST_ITER_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ITER && stepCntQ == LAST_STEP) |=> stateQ == ST_FIX); // R5
  AST_ZERO_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ABS_DIVIDEND && divZero) |=> stateQ == ST_IDLE); // R6
  AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_IDLE) |-> !strobes.loadOps); // R9

endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobes_t      strobes,
  input  logic [1:0]       opSelIn,
  input  logic [WIDTH-1:0] dividendIn,
  input  logic [WIDTH-1:0] divisorIn,
  output logic             divZero,
  output logic [WIDTH-1:0] resultOut,
  output logic             validOut
);

  logic [1:0]       opSelQ;
  logic [WIDTH-1:0] dividendQ, divisorQ, absDivisorQ, remQ, quoQ;
  logic             zeroQ;
  logic             isSigned, isRem, negQuo, negRem;
  logic [WIDTH:0]   candidate;
  logic [WIDTH+1:0] trialDiff;
  logic             borrow;
  logic [WIDTH-1:0] quoFinal, remFinal;

  assign isSigned = !opIsUnsigned(opSelQ);
  assign isRem    = opIsRem(opSelQ);
  assign negQuo   = isSigned && (dividendQ[WIDTH-1] ^ divisorQ[WIDTH-1]);
  assign negRem   = isSigned && dividendQ[WIDTH-1];
  assign divZero  = zeroQ;

  assign candidate = {remQ, quoQ[WIDTH-1]};
  assign trialDiff = {1'b0, candidate} - {2'b00, absDivisorQ};
  assign borrow    = trialDiff[WIDTH+1];

  assign quoFinal = negQuo ? (~quoQ + 1'b1) : quoQ;
  assign remFinal = negRem ? (~remQ + 1'b1) : remQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opSelQ      <= '0;
      dividendQ   <= '0;
      divisorQ    <= '0;
      absDivisorQ <= '0;
      zeroQ       <= 1'b0;
      remQ        <= '0;
      quoQ        <= '0;
      resultOut   <= '0;
      validOut    <= 1'b0;
    end else begin
      validOut <= strobes.finish || strobes.zeroExit;
      if (strobes.loadOps) begin
        opSelQ    <= opSelIn;
        dividendQ <= dividendIn;
        divisorQ  <= divisorIn;
        zeroQ     <= (divisorIn == '0);
      end
      if (strobes.absDividend) begin
        quoQ <= (isSigned && dividendQ[WIDTH-1]) ? (~dividendQ + 1'b1) : dividendQ;
      end
      if (strobes.absDivisor) begin
        absDivisorQ <= (isSigned && divisorQ[WIDTH-1]) ? (~divisorQ + 1'b1) : divisorQ;
      end
      if (strobes.prep) begin
        remQ <= '0;
      end
      if (strobes.step) begin
        if (!borrow) begin
          remQ <= trialDiff[WIDTH-1:0];
          quoQ <= {quoQ[WIDTH-2:0], 1'b1};
        end else begin
          remQ <= candidate[WIDTH-1:0];
          quoQ <= {quoQ[WIDTH-2:0], 1'b0};
        end
      end
      if (strobes.finish) begin
        resultOut <= isRem ? remFinal : quoFinal;
      end else if (strobes.zeroExit) begin
        resultOut <= isRem ? dividendQ : '1;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    validOut |=> !validOut); // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.finish || strobes.zeroExit) |=> $stable(resultOut)); // R8
  AST_OP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadOps |=> ($stable(opSelQ) && $stable(dividendQ) && $stable(divisorQ))); // R9
  AST_ZERO_QUOTIENT: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && zeroQ && !isRem) |-> resultOut == '1); // R6
  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && !zeroQ) |-> remQ < absDivisorQ); // R4

endmodule

// File: rtl/iterDivider.sv
module iterDivider
  import divPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       opSel,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] result,
  output logic             valid
);

  divStrobes_t strobes;
  logic        divZero;

  divControl #(.WIDTH(WIDTH)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .divZero (divZero),
    .strobes (strobes)
  );

  divDatapath #(.WIDTH(WIDTH)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .opSelIn    (opSel),
    .dividendIn (dividend),
    .divisorIn  (divisor),
    .divZero    (divZero),
    .resultOut  (result),
    .validOut   (valid)
  );

endmodule

// File: tb/tb_iterDivider.sv
module tb_iterDivider;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opSel = '0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic [31:0] result;
  logic        valid;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  iterDivider dut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .dividend(dividend), .divisor(divisor), .result(result), .valid(valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] refOut(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    if (b == 0) return op[1] ? a : 32'hFFFF_FFFF;
    if (op[0]) return op[1] ? (a % b) : (a / b);
    if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return op[1] ? 32'h0 : 32'h8000_0000;
    return op[1] ? 32'($signed(a) % $signed(b)) : 32'($signed(a) / $signed(b));
  endfunction

  function automatic string reqFor(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    if (b == 0) return "R6";
    if (!op[0] && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return "R7";
    if (op[0]) return "R2";
    return op[1] ? "R4" : "R3";
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b, input bit poke);
    int lat;
    int expLat;
    logic [31:0] expRes;
    expLat = (b == 0) ? 2 : 37;
    expRes = refOut(op, a, b);
    @(negedge clk);
    opSel = op; dividend = a; divisor = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!valid && lat < 100) begin
      if (poke && lat < 30) begin
        start = 1'b1; opSel = 2'($urandom); dividend = $urandom; divisor = $urandom; // R9 stimulus
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check(lat == expLat, (b == 0) ? "R6 latency" : (poke ? "R9 latency" : "R5 latency"), 32'(lat), 32'(expLat));
    check(result == expRes, poke ? "R9 result" : reqFor(op, a, b), result, expRes);
    @(negedge clk);
    check(!valid && result == expRes, "R8 pulse/hold", {31'b0, valid}, 32'h0);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd7331);
    repeat (3) @(negedge clk);
    check(valid == 1'b0 && result == 0, "R1 in reset", result, 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(valid == 1'b0 && result == 0, "R1 after reset", result, 32'h0);

    runOp(2'b00, 32'd100, 32'd7, 0);
    runOp(2'b00, -32'sd100, 32'd7, 0);
    runOp(2'b00, 32'd100, -32'sd7, 0);
    runOp(2'b10, -32'sd100, 32'd7, 0);
    runOp(2'b10, 32'd100, -32'sd7, 0);
    runOp(2'b01, 32'hFFFF_FFFF, 32'd3, 0);
    runOp(2'b11, 32'hFFFF_FFFF, 32'd10, 0);
    runOp(2'b00, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    runOp(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    runOp(2'b00, 32'h1234_5678, 32'd0, 0);
    runOp(2'b10, 32'h8765_4321, 32'd0, 0);
    runOp(2'b01, 32'hDEAD_BEEF, 32'd0, 0);
    runOp(2'b11, 32'hCAFE_F00D, 32'd0, 0);
    runOp(2'b01, 32'd5, 32'hFFFF_FFFF, 0);
    runOp(2'b00, 32'd12345, 32'd1, 1);
    runOp(2'b10, -32'sd77, 32'd5, 1);

    for (int i = 0; i < 60; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      if (i % 3 == 0) b = b & 32'h0000_00FF;
      else if (i % 3 == 1) b = b & 32'h000F_FFFF;
      if (i % 15 == 0) b = 0;
      runOp(2'($urandom), a, b, (i % 10) == 5);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule